// File: doc/BRIEF.md
# Analog Joystick Position Port

This block lets software read two analog joysticks, A and B. Each joystick has an X axis, a Y axis and two buttons. Each axis line connects to an external resistor–capacitor network. The joystick's potentiometer sets how fast that network charges.

A host write strobe at the status offset starts a measurement in three steps:

1. The block pulls all four axis lines low for a programmable number of clocks, which empties the capacitors.
2. It then lets the lines go.
3. It holds one busy flag per axis at 1 until that line, after passing through a synchronizer, is seen high again.

Software polls the status offset and times how long each flag stays set. A longer time means a larger resistance, and so a different stick position.

The same status offset also returns the four button levels exactly as they are on the pins. Software does any debouncing it needs.

Top module: `joyport_top`

## Requirements
- R1: After reset, `axis_drive_low` is 0000b and status bits 3..0 read 0.
- R2: A read at offset 1 returns the raw button pins in bits 7..4 in the same cycle: bit 7 = `btn_in[3]` (joystick B button 1), bit 6 = `btn_in[2]` (B button 0), bit 5 = `btn_in[1]` (A button 1), bit 4 = `btn_in[0]` (A button 0). A 1 means the pin is high.
- R3: Status bits 3..0 are the axis busy flags. Bit 3 = B Y, bit 2 = B X, bit 1 = A Y, bit 0 = A X. Bit i belongs to `axis_in[i]` and `axis_drive_low[i]`.
- R4: When `host_wr` is high with `host_addr` = 1 at a clock edge, all four bits of `axis_drive_low` are 1 and all four busy flags are 1 from the next cycle on. The lines stay driven for exactly PULSE_CYC cycles.
- R5: Suppose an axis pin is first seen high in cycle N (N ≥ 1) after release. Its busy flag then reads 1 for exactly PULSE_CYC + N + SYNC_STAGES cycles, counted from the trigger edge. An axis that is high at once behaves as N = 1.
- R6: Pin levels during the discharge pulse, and during the SYNC_STAGES cycles after release, are ignored. A pin stuck high therefore keeps its flag at 1 for PULSE_CYC + SYNC_STAGES + 1 cycles.
- R7: A busy flag whose pin never goes high stays 1 until the next trigger.
- R8: A trigger during an active pulse or an active measurement restarts the pulse and sets all four flags again. The timing of R4 and R5 is then counted from the new trigger.
- R9: Writes to any offset other than 1 change neither `axis_drive_low` nor the busy flags. Reads of any offset other than 1 return 00h.
- R10: The four busy flags clear independently, each on its own pin's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | ADDR_W | Register offset within the port's address window |
| host_wr | input | 1 | Write strobe; a strobe at offset 1 starts a measurement |
| host_rdata | output | 8 | Read data for `host_addr`, combinational |
| btn_in | input | 4 | Button pins {B1, B0, A1, A0} |
| axis_in | input | 4 | Axis pin levels {BY, BX, AY, AX} |
| axis_drive_low | output | 4 | 1 = pull the matching axis line low (output enable of an open-drain driver) |

## Verification
A wrong phase or count in the discharge sequencer shows up first at `axis_drive_low`, one cycle after the trigger. It also changes the length of every busy interval by the same amount, so a sweep over charge delays sees an offset on all four axes at once.

A wrong busy flag shows at status bits 3..0 within one cycle of the pin edge that should have cleared it. A stale synchronizer sample clears the flag early. A bad lane mapping makes one axis take another axis's charge time.

Running the sweep with different delays on every axis catches both kinds of fault inside a single measurement.

// File: rtl/joyport_pkg.sv
package joyport_pkg;

    // Offset of the combined button/axis status register.
    localparam int STATUS_OFS = 1;

    // Number of axis lanes and button inputs.
    localparam int N_AXES = 4;
    localparam int N_BTNS = 4;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_DISCH  = 2'd1,
        PH_SETTLE = 2'd2,
        PH_MEAS   = 2'd3
    } phase_e;

endpackage

// File: rtl/joyport_sync.sv
module joyport_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/joyport_seq.sv
module joyport_seq
    import joyport_pkg::*;
#(
    parameter int PULSE_CYC   = 16,
    parameter int SYNC_STAGES = 2,
    parameter int N_LINES     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trigger,
    output logic [N_LINES-1:0] drive_low,
    output logic               sample_en
);
    localparam int MAXC  = (PULSE_CYC > SYNC_STAGES) ? PULSE_CYC : SYNC_STAGES;
    localparam int CNT_W = $clog2(MAXC + 1);

    typedef struct packed {
        phase_e     phase;
        logic [CNT_W-1:0] cnt;
        logic       drive;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (trigger) begin
            s_d.phase = PH_DISCH;
            s_d.cnt   = CNT_W'(PULSE_CYC - 1);
            s_d.drive = 1'b1;
        end else begin
            unique case (s_q.phase)
                PH_DISCH: begin
                    if (s_q.cnt == '0) begin
                        s_d.phase = PH_SETTLE;
                        s_d.cnt   = CNT_W'(SYNC_STAGES - 1);
                        s_d.drive = 1'b0;
                    end else begin
                        s_d.cnt = s_q.cnt - CNT_W'(1);
                    end
                end
                PH_SETTLE: begin
                    if (s_q.cnt == '0) begin
                        s_d.phase = PH_MEAS;
                    end else begin
                        s_d.cnt = s_q.cnt - CNT_W'(1);
                    end
                end
                PH_MEAS:  s_d = s_q;
                default:  s_d = s_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, cnt: '0, drive: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign drive_low = {N_LINES{s_q.drive}};
    assign sample_en = (s_q.phase == PH_MEAS);
endmodule

// File: rtl/joyport_axis.sv
module joyport_axis #(
    parameter int N_LINES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trigger,
    input  logic               sample_en,
    input  logic [N_LINES-1:0] pin_sync,
    output logic [N_LINES-1:0] busy
);
    logic [N_LINES-1:0] busy_d, busy_q;

    for (genvar i = 0; i < N_LINES; i++) begin : g_lane
        always_comb begin
            if (trigger) begin
                busy_d[i] = 1'b1;
            end else if (sample_en && pin_sync[i]) begin
                busy_d[i] = 1'b0;
            end else begin
                busy_d[i] = busy_q[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else begin
            busy_q <= busy_d;
        end
    end

    assign busy = busy_q;
endmodule

// File: rtl/joyport_host.sv
module joyport_host
    import joyport_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [N_BTNS-1:0] btn_lvl,
    input  logic [N_AXES-1:0] axis_busy,
    output logic              trigger,
    output logic [7:0]        rdata
);
    logic hit;

    always_comb begin
        hit     = (host_addr == ADDR_W'(STATUS_OFS));
        trigger = hit && host_wr;
        rdata   = hit ? {btn_lvl, axis_busy} : 8'h00;
    end
endmodule

// File: rtl/joyport_top.sv
module joyport_top
    import joyport_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int PULSE_CYC   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    output logic [7:0]        host_rdata,
    input  logic [3:0]        btn_in,
    input  logic [3:0]        axis_in,
    output logic [3:0]        axis_drive_low
);
    logic              trig;
    logic              sample_en;
    logic [N_AXES-1:0] pin_sync;
    logic [N_AXES-1:0] axis_busy_q;

    joyport_host #(.ADDR_W(ADDR_W)) host_i (
        .host_addr (host_addr),
        .host_wr   (host_wr),
        .btn_lvl   (btn_in),
        .axis_busy (axis_busy_q),
        .trigger   (trig),
        .rdata     (host_rdata)
    );

    joyport_seq #(
        .PULSE_CYC   (PULSE_CYC),
        .SYNC_STAGES (SYNC_STAGES),
        .N_LINES     (N_AXES)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .trigger   (trig),
        .drive_low (axis_drive_low),
        .sample_en (sample_en)
    );

    joyport_sync #(.WIDTH(N_AXES), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (axis_in),
        .dout  (pin_sync)
    );

    joyport_axis #(.N_LINES(N_AXES)) axis_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .trigger   (trig),
        .sample_en (sample_en),
        .pin_sync  (pin_sync),
        .busy      (axis_busy_q)
    );
endmodule

// File: rtl/joyport_chk.sv
module joyport_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_wr,
    input logic [3:0]        axis_drive_low,
    input logic [3:0]        axis_busy
);
    logic fire;
    assign fire = host_wr && (host_addr == ADDR_W'(1));

    AST_DRIVE_AFTER_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (axis_drive_low == 4'hF)); // R4

    AST_BUSY_AFTER_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (axis_busy == 4'hF)); // R8

    AST_NO_SET_WITHOUT_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> ((axis_busy & ~$past(axis_busy)) == 4'h0)); // R9

    AST_HOLD_WHILE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (axis_drive_low != 4'h0) |=> (axis_busy == 4'hF)); // R6

    AST_DRIVE_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (axis_drive_low == 4'h0) || (axis_drive_low == 4'hF)); // R4

    AST_NO_DRIVE_WITHOUT_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && axis_drive_low == 4'h0) |=> (axis_drive_low == 4'h0)); // R9
endmodule

bind joyport_top joyport_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .host_addr      (host_addr),
    .host_wr        (host_wr),
    .axis_drive_low (axis_drive_low),
    .axis_busy      (axis_busy_q)
);

// File: tb/joyport_top_tb.sv
module joyport_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int P          = 16;
    localparam int SY         = 2;
    localparam int LIMIT      = 300;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] host_addr = 4'd1;
    logic       host_wr = 1'b0;
    logic [7:0] host_rdata;
    logic [3:0] btn_in = 4'h0;
    logic [3:0] axis_in = 4'h0;
    logic [3:0] axis_drive_low;

    int n_chg [4];
    bit stuck_hi [4];
    int rel_cnt [4];
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    joyport_top #(.ADDR_W(4), .PULSE_CYC(P), .SYNC_STAGES(SY)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .host_addr      (host_addr),
        .host_wr        (host_wr),
        .host_rdata     (host_rdata),
        .btn_in         (btn_in),
        .axis_in        (axis_in),
        .axis_drive_low (axis_drive_low)
    );

    // RC line model: updates on the falling edge.
    always @(negedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (stuck_hi[i]) begin
                axis_in[i] <= 1'b1;
            end else if (axis_drive_low[i]) begin
                rel_cnt[i] = 0;
                axis_in[i] <= 1'b0;
            end else begin
                if (rel_cnt[i] < 1000000) rel_cnt[i] = rel_cnt[i] + 1;
                axis_in[i] <= (n_chg[i] >= 0) && (rel_cnt[i] >= n_chg[i]);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(input int n);
        if (n < 0) return LIMIT;
        return P + ((n < 1) ? 1 : n) + SY;
    endfunction

    task automatic trig();
        @(negedge clk);
        host_addr = 4'd1;
        host_wr   = 1'b1;
        @(posedge clk);
        #1 host_wr = 1'b0;
    endtask

    // Trigger, then count the cycles each flag stays set.
    task automatic measure(input string req, input int a, input int b,
                           input int c, input int d);
        int cnt [4];
        int drv;
        n_chg[0] = a; n_chg[1] = b; n_chg[2] = c; n_chg[3] = d;
        cnt = '{0, 0, 0, 0};
        drv = 0;
        trig();
        for (int k = 0; k < LIMIT; k++) begin
            @(negedge clk);
            #1;
            for (int i = 0; i < 4; i++) if (host_rdata[i]) cnt[i]++;
            if (axis_drive_low == 4'hF) drv++;
            if (host_rdata[3:0] == 4'h0) break;
        end
        chk({req, " R4 pulse"}, drv, P);
        for (int i = 0; i < 4; i++) begin
            chk({req, " R5/R10 lane"}, cnt[i],
                stuck_hi[i] ? P + SY + 1 : exp_len(n_chg[i]));
        end
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            n_chg[i] = 3; stuck_hi[i] = 1'b0; rel_cnt[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R1
        chk("R1 drive", int'(axis_drive_low), 0);
        chk("R1 status", int'(host_rdata[3:0]), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: all button patterns, live
        for (int p = 0; p < 16; p++) begin
            btn_in = p[3:0];
            #1;
            chk("R2 buttons", int'(host_rdata[7:4]), p);
        end
        btn_in = 4'h0;

        // R3/R5/R10: sweep charge delays, different on every lane
        for (int n = 0; n <= 20; n++) begin
            measure("R3 sweep", n, n + 3, 2 * n + 1, 25 - n);
        end

        // R7: lanes that never charge stay busy, then recover on the next trigger
        measure("R7 never", -1, 5, -1, 5);
        measure("R7 recover", 4, 6, 8, 10);

        // R6: pin stuck high is ignored during discharge and settling
        stuck_hi[0] = 1'b1;
        measure("R6 stuck", 0, 4, 4, 4);
        stuck_hi[0] = 1'b0;

        // R8: restart mid-measurement
        n_chg = '{10, 10, 10, 10};
        trig();
        repeat (8) @(negedge clk);
        measure("R8 restart in pulse", 10, 12, 14, 16);
        trig();
        repeat (P + 6) @(negedge clk);
        measure("R8 restart in meas", 9, 7, 5, 3);

        // R9: other offsets are neither triggers nor readable
        for (int a = 0; a < 16; a++) begin
            if (a == 1) continue;
            @(negedge clk);
            host_addr = a[3:0];
            host_wr = 1'b1;
            btn_in = 4'hA;
            #1;
            chk("R9 read other", int'(host_rdata), 0);
            @(posedge clk);
            #1 host_wr = 1'b0;
            host_addr = 4'd1;
            @(negedge clk);
            #1;
            chk("R9 no drive", int'(axis_drive_low), 0);
            chk("R9 no busy", int'(host_rdata[3:0]), 0);
        end
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule